// File: doc/BRIEF.md
# Erase and Program Sequencer with Suspend

This block carries out the automated write operations of a block-organised nonvolatile array: erasing a block, programming a page and setting a block's lock bit. The command decoder hands it one operation at a time over a valid/ready request channel. The block then runs a loop that repeats the same two steps until the array reports success. First it applies a pulse that lasts a fixed number of cycles. Then it spends one cycle asking the array whether the cells verify. The array answers through the verify handshake: `vfy_req` is high in the verify cycle, and the array returns its result on `vfy_ok` in that same cycle.

The sequencer holds one lock bit per block, where 1 means unlocked and 0 means locked. It compares the lock bit against the write-protect pin and a high-voltage override input. It can pause an operation on request and later continue it from the point where it stopped. An abort input ends any operation at once and marks the affected block's contents as invalid. Status is reported on plain flags: busy, suspended, erase error and program error.

The request channel has the following back-pressure rule. `req_ready` is high only when the sequencer is idle, meaning it is neither running nor suspended. A request is taken in a cycle where `req_valid` and `req_ready` are both high. While `req_ready` is low, the decoder must hold its request.

Top module: `flash_seq`

## Requirements
- R1: After reset, `busy`, `suspended`, `erase_err`, `prog_err` and every `invalid_bits` bit are 0, and `req_ready` and every `lock_bits` bit are 1.
- R2: Operation codes on `req_op` are 0 for erase, 1 for program and 2 for lock-bit set; code 3 runs as program. An accepted operation alternates two steps: a pulse of PULSE_CYC cycles, then one verify cycle with `vfy_req` high. It stops after the first verify cycle in which `vfy_ok` is 1.
- R3: `busy` is 1 from the cycle after acceptance through the final verify cycle, and 0 otherwise. `req_ready` is 1 only while the sequencer is idle and not suspended.
- R4: A lock-bit operation is never refused. When it verifies, it clears that block's `lock_bits` bit to 0.
- R5: When `wp_n` is 0 and `hv_override` is 0, an erase or program request to a block whose lock bit is 0 is refused. A refused request raises no `busy` and no `vfy_req`. It sets `erase_err` for an erase and `prog_err` for a program. Both error flags are cleared whenever a later request is accepted.
- R6: An erase that was accepted while `wp_n` or `hv_override` was 1 is unprotected. When such an erase succeeds, it sets that block's lock bit back to 1, and all blocks may be erased or programmed under these conditions.
- R7: If MAX_PULSES verify cycles all fail, the operation ends. It sets `erase_err` for an erase, or `prog_err` for a program or lock operation, and returns to idle.
- R8: A `susp_req` pulse during a pulse or verify cycle moves the sequencer to suspended in the next cycle. While suspended, `suspended` is 1, `busy` is 0, `req_ready` is 0 and no pulse or verify progresses.
- R9: A `susp_req` while idle is ignored: `suspended` stays 0 and `req_ready` stays 1.
- R10: A `resume_req` while suspended clears `suspended` and continues the operation from the step it was in. The cycle in which the suspend was taken does not consume a pulse cycle.
- R11: An `abort_req` while running or suspended returns the sequencer to idle in the next cycle and sets that block's `invalid_bits` bit. Abort takes precedence over a suspend in the same cycle. A later successful erase of the block clears the invalid bit.
- R12: When a suspend arrives in a verify cycle, the suspend wins and that verify result is discarded. After the resume, the verify cycle is repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation request valid |
| req_ready | output | 1 | Sequencer can accept a request |
| req_op | input | 2 | Operation code (0 erase, 1 program, 2 lock) |
| req_blk | input | BLK_W | Target block index |
| susp_req | input | 1 | Suspend request pulse |
| resume_req | input | 1 | Resume request pulse |
| abort_req | input | 1 | Abort (power-down) request |
| wp_n | input | 1 | Write-protect, low enables lock checking |
| hv_override | input | 1 | Override that unlocks all blocks |
| vfy_req | output | 1 | Verify cycle, array result expected |
| vfy_ok | input | 1 | Array verify result for this cycle |
| busy | output | 1 | Operation in progress |
| suspended | output | 1 | Operation paused |
| erase_err | output | 1 | Erase refused or failed |
| prog_err | output | 1 | Program or lock operation refused or failed |
| lock_bits | output | NBLK | Per-block lock bits, 0 means locked |
| invalid_bits | output | NBLK | Per-block contents-invalid flags |

## Verification
Suspend can land in the same cycle as a verify result, and abort can land in the same cycle as a suspend. The bench provokes the first case by watching for `vfy_req` and raising `susp_req` in that verify cycle while the array model answers pass. It judges the outcome by requiring that the sequencer ends up suspended and error-free, and that the verify cycle is counted once more after the resume. For the second case, abort and suspend are raised together in a pulse cycle. The result must be idle, not suspended, with the block's invalid bit set.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {
    OP_ERASE = 2'd0,
    OP_PROG  = 2'd1,
    OP_LOCK  = 2'd2,
    OP_PROG2 = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PULSE  = 2'd1,
    ST_VERIFY = 2'd2,
    ST_SUSP   = 2'd3
  } st_e;
endpackage

// File: rtl/pulse_timer.sv
module pulse_timer #(
  parameter int PULSE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic last
);
  localparam int CW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
  localparam logic [CW-1:0] LAST_V = CW'(PULSE_CYC - 1);

  logic [CW-1:0] cnt;

  assign last = (cnt == LAST_V);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (run) cnt <= last ? '0 : cnt + 1'b1;
  end

  // R2: the pulse counter never passes the configured pulse length
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST_V);
  // R10: a held (suspended) pulse keeps its position
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt));
endmodule

// File: rtl/lock_store.sv
module lock_store #(
  parameter int NBLK  = 8,
  parameter int BLK_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BLK_W-1:0] cur_blk,
  input  logic             ev_erase_ok,
  input  logic             ev_lock_ok,
  input  logic             ev_abort,
  input  logic             byp,
  output logic [NBLK-1:0]  lock_bits,
  output logic [NBLK-1:0]  invalid_bits
);
  for (genvar i = 0; i < NBLK; i++) begin : g_blk
    logic hit;
    assign hit = (cur_blk == BLK_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lock_bits[i]    <= 1'b1;
        invalid_bits[i] <= 1'b0;
      end else if (hit) begin
        if (ev_lock_ok) lock_bits[i] <= 1'b0;
        else if (ev_erase_ok && byp) lock_bits[i] <= 1'b1;
        if (ev_abort) invalid_bits[i] <= 1'b1;
        else if (ev_erase_ok) invalid_bits[i] <= 1'b0;
      end
    end
  end

  // R4: a verified lock operation leaves its block locked
  p_lock_prog_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lock_ok |=> !lock_bits[$past(cur_blk)]);
  // R11: an abort marks its block invalid
  p_inv_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> invalid_bits[$past(cur_blk)]);
  // R6: an unprotected erase success unlocks its block
  p_unlock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_erase_ok && byp && !ev_abort) |=> lock_bits[$past(cur_blk)]);
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int BLK_W      = 3,
  parameter int MAX_PULSES = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [BLK_W-1:0] req_blk,
  output logic             req_ready,
  input  logic             susp_req,
  input  logic             resume_req,
  input  logic             abort_req,
  input  logic             protect_on,
  input  logic             blk_locked,
  output logic             vfy_req,
  input  logic             vfy_ok,
  input  logic             pulse_last,
  output logic             timer_run,
  output logic             timer_clr,
  output logic             busy,
  output logic             suspended,
  output logic             erase_err,
  output logic             prog_err,
  output logic [BLK_W-1:0] cur_blk,
  output logic             byp_q,
  output logic             ev_erase_ok,
  output logic             ev_lock_ok,
  output logic             ev_abort
);
  localparam int TRY_W = $clog2(MAX_PULSES + 1);
  localparam logic [TRY_W-1:0] TRY_MAX = TRY_W'(MAX_PULSES);

  st_e             state, ret_state;
  op_e             op_q, op_in;
  logic [TRY_W-1:0] tries;
  logic            accept, refuse, running, halt, done_ok;

  assign op_in     = op_e'(req_op);
  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign refuse    = protect_on && blk_locked && (op_in != OP_LOCK);
  assign running   = (state == ST_PULSE) || (state == ST_VERIFY);
  assign busy      = running;
  assign suspended = (state == ST_SUSP);
  assign vfy_req   = (state == ST_VERIFY);
  assign halt      = abort_req || susp_req;
  assign timer_run = (state == ST_PULSE) && !halt;
  assign timer_clr = accept || abort_req;
  assign done_ok   = vfy_req && !halt && vfy_ok;
  assign ev_erase_ok = done_ok && (op_q == OP_ERASE);
  assign ev_lock_ok  = done_ok && (op_q == OP_LOCK);
  assign ev_abort    = abort_req && (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ret_state <= ST_PULSE;
      op_q      <= OP_ERASE;
      cur_blk   <= '0;
      byp_q     <= 1'b0;
      tries     <= '0;
      erase_err <= 1'b0;
      prog_err  <= 1'b0;
    end else if (ev_abort) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          erase_err <= 1'b0;
          prog_err  <= 1'b0;
          if (refuse) begin
            if (op_in == OP_ERASE) erase_err <= 1'b1;
            else prog_err <= 1'b1;
          end else begin
            state   <= ST_PULSE;
            op_q    <= op_in;
            cur_blk <= req_blk;
            byp_q   <= !protect_on;
            tries   <= TRY_W'(1);
          end
        end
        ST_PULSE: begin
          if (susp_req) begin
            ret_state <= ST_PULSE;
            state     <= ST_SUSP;
          end else if (pulse_last) begin
            state <= ST_VERIFY;
          end
        end
        ST_VERIFY: begin
          if (susp_req) begin
            ret_state <= ST_VERIFY;
            state     <= ST_SUSP;
          end else if (vfy_ok) begin
            state <= ST_IDLE;
          end else if (tries == TRY_MAX) begin
            state <= ST_IDLE;
            if (op_q == OP_ERASE) erase_err <= 1'b1;
            else prog_err <= 1'b1;
          end else begin
            tries <= tries + 1'b1;
            state <= ST_PULSE;
          end
        end
        ST_SUSP: if (resume_req) state <= ret_state;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: running and suspended never coincide
  p_busy_susp_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && suspended));
  // R8: a suspend during an operation is taken next cycle
  p_susp_enter_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && susp_req && !abort_req) |=> suspended);
  // R9: suspend while idle leaves the sequencer unsuspended
  p_susp_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && susp_req) |=> !suspended);
  // R11: abort returns to idle
  p_abort_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (state == ST_IDLE));
  // R5: a refused request never starts
  p_refuse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && refuse) |=> !busy);
  // R7: pulse attempts stay within the limit
  p_tries_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tries <= TRY_MAX);
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int NBLK       = 8,
  parameter int PULSE_CYC  = 4,
  parameter int MAX_PULSES = 6,
  localparam int BLK_W     = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [BLK_W-1:0] req_blk,
  input  logic             susp_req,
  input  logic             resume_req,
  input  logic             abort_req,
  input  logic             wp_n,
  input  logic             hv_override,
  output logic             vfy_req,
  input  logic             vfy_ok,
  output logic             busy,
  output logic             suspended,
  output logic             erase_err,
  output logic             prog_err,
  output logic [NBLK-1:0]  lock_bits,
  output logic [NBLK-1:0]  invalid_bits
);
  logic             protect_on, blk_locked, pulse_last, timer_run, timer_clr;
  logic             byp_q, ev_erase_ok, ev_lock_ok, ev_abort;
  logic [BLK_W-1:0] cur_blk;

  assign protect_on = !wp_n && !hv_override;
  assign blk_locked = !lock_bits[req_blk];

  seq_ctrl #(.BLK_W(BLK_W), .MAX_PULSES(MAX_PULSES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_blk(req_blk), .req_ready(req_ready), .susp_req(susp_req),
    .resume_req(resume_req), .abort_req(abort_req), .protect_on(protect_on),
    .blk_locked(blk_locked), .vfy_req(vfy_req), .vfy_ok(vfy_ok),
    .pulse_last(pulse_last), .timer_run(timer_run), .timer_clr(timer_clr),
    .busy(busy), .suspended(suspended), .erase_err(erase_err),
    .prog_err(prog_err), .cur_blk(cur_blk), .byp_q(byp_q),
    .ev_erase_ok(ev_erase_ok), .ev_lock_ok(ev_lock_ok), .ev_abort(ev_abort)
  );

  pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(timer_run), .clr(timer_clr),
    .last(pulse_last)
  );

  lock_store #(.NBLK(NBLK), .BLK_W(BLK_W)) u_store (
    .clk(clk), .rst_n(rst_n), .cur_blk(cur_blk), .ev_erase_ok(ev_erase_ok),
    .ev_lock_ok(ev_lock_ok), .ev_abort(ev_abort), .byp(byp_q),
    .lock_bits(lock_bits), .invalid_bits(invalid_bits)
  );

  // R3: no request is taken while an operation runs or is paused
  p_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || suspended) |-> !req_ready);
endmodule

// File: tb/sim_flash_seq.sv
module sim_flash_seq;
  localparam int NBLK = 8, PC = 4, MAXP = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, susp_req = 0, resume_req = 0, abort_req = 0;
  logic wp_n = 1, hv_override = 0, vfy_ok = 0;
  logic [1:0] req_op = 0;
  logic [2:0] req_blk = 0;
  logic req_ready, vfy_req, busy, suspended, erase_err, prog_err;
  logic [NBLK-1:0] lock_bits, invalid_bits;

  int checks = 0, failures = 0;
  int vfy_cnt = 0, pass_at = 1;

  always #4 clk = ~clk;

  flash_seq #(.NBLK(NBLK), .PULSE_CYC(PC), .MAX_PULSES(MAXP)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_blk(req_blk), .susp_req(susp_req),
    .resume_req(resume_req), .abort_req(abort_req), .wp_n(wp_n),
    .hv_override(hv_override), .vfy_req(vfy_req), .vfy_ok(vfy_ok),
    .busy(busy), .suspended(suspended), .erase_err(erase_err),
    .prog_err(prog_err), .lock_bits(lock_bits), .invalid_bits(invalid_bits)
  );

  // array model: passes on the pass_at-th verify of the current operation
  always @(negedge clk) begin
    if (vfy_req) begin
      vfy_cnt = vfy_cnt + 1;
      vfy_ok  = (vfy_cnt >= pass_at);
    end else vfy_ok = 1'b0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [2:0] blk, input int pa);
    vfy_cnt = 0; pass_at = pa;
    @(negedge clk); req_valid = 1; req_op = op; req_blk = blk;
    @(negedge clk); req_valid = 0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    for (int g = 0; g < 2000; g++) begin
      if (!busy && !suspended) break;
      if (busy) n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk(!busy && !suspended && !erase_err && !prog_err, "R1 flags", busy, 0);
    chk(req_ready == 1, "R1 ready", req_ready, 1);
    chk(lock_bits == '1 && invalid_bits == '0, "R1 store", lock_bits, 255);
  endtask

  task automatic t_erase_loop();
    int n;
    issue(2'd0, 3'd1, 3);
    count_busy(n);
    chk(n == 3*(PC+1), "R3 busy span", n, 3*(PC+1));
    chk(vfy_cnt == 3, "R2 verify count", vfy_cnt, 3);
    chk(!erase_err && req_ready, "R2 clean finish", erase_err, 0);
  endtask

  task automatic t_lock_protect();
    int n;
    issue(2'd2, 3'd2, 1);
    count_busy(n);
    chk(lock_bits[2] == 0, "R4 lock set", lock_bits[2], 0);
    chk(n == PC+1, "R4 lock busy", n, PC+1);
    wp_n = 0;
    issue(2'd1, 3'd2, 1);
    count_busy(n);
    chk(n == 0 && vfy_cnt == 0, "R5 refused no run", n, 0);
    chk(prog_err && !erase_err, "R5 prog_err", prog_err, 1);
    issue(2'd0, 3'd2, 1);
    count_busy(n);
    chk(erase_err && !prog_err, "R5 erase_err, prog_err cleared", erase_err, 1);
    issue(2'd1, 3'd4, 1);
    count_busy(n);
    chk(n == PC+1 && !prog_err && !erase_err, "R5 unlocked block runs", n, PC+1);
    hv_override = 1;
    issue(2'd0, 3'd2, 1);
    count_busy(n);
    chk(lock_bits[2] == 1 && !erase_err, "R6 override erase unlocks", lock_bits[2], 1);
    hv_override = 0;
    issue(2'd2, 3'd6, 1);
    count_busy(n);
    wp_n = 1;
    issue(2'd0, 3'd6, 2);
    count_busy(n);
    chk(lock_bits[6] == 1 && n == 2*(PC+1), "R6 wp high erase unlocks", lock_bits[6], 1);
  endtask

  task automatic t_max_pulses();
    int n;
    issue(2'd1, 3'd0, 100);
    count_busy(n);
    chk(prog_err && !erase_err, "R7 prog_err", prog_err, 1);
    chk(n == MAXP*(PC+1) && vfy_cnt == MAXP, "R7 pulse limit", vfy_cnt, MAXP);
    issue(2'd0, 3'd0, 100);
    count_busy(n);
    chk(erase_err && !prog_err, "R7 erase_err", erase_err, 1);
  endtask

  task automatic t_suspend();
    int n, m, v;
    issue(2'd1, 3'd3, 2);
    n = 0;
    for (int k = 0; k < 3; k++) begin
      if (busy) n++;
      if (k < 2) @(negedge clk);
    end
    susp_req = 1; @(negedge clk); susp_req = 0;
    chk(suspended && !busy && !req_ready, "R8 suspended state", suspended, 1);
    v = vfy_cnt;
    repeat (6) @(negedge clk);
    chk(suspended && vfy_cnt == v, "R8 no progress", vfy_cnt, v);
    req_valid = 1; req_op = 2'd0; req_blk = 3'd7;
    @(negedge clk); req_valid = 0;
    chk(suspended && invalid_bits == '0 && !busy, "R8 request held off", busy, 0);
    resume_req = 1; @(negedge clk); resume_req = 0;
    chk(!suspended && busy, "R10 resumed", suspended, 0);
    count_busy(m);
    chk(n + m == 2*(PC+1) + 1, "R10 continue point", n + m, 2*(PC+1) + 1);
    chk(vfy_cnt == 2 && !prog_err, "R10 completes", vfy_cnt, 2);
  endtask

  task automatic t_idle_suspend();
    int n;
    @(negedge clk); susp_req = 1; @(negedge clk); susp_req = 0;
    chk(!suspended && req_ready, "R9 idle suspend ignored", suspended, 0);
    issue(2'd1, 3'd1, 1);
    count_busy(n);
    chk(n == PC+1, "R9 later op normal", n, PC+1);
  endtask

  task automatic t_verify_suspend();
    int n;
    issue(2'd0, 3'd3, 1);
    for (int g = 0; g < 100; g++) begin
      #1; if (vfy_req) break;
      @(negedge clk);
    end
    susp_req = 1; @(negedge clk); susp_req = 0;
    chk(suspended && !erase_err && vfy_cnt == 1, "R12 suspend beats verify", suspended, 1);
    repeat (3) @(negedge clk);
    resume_req = 1; @(negedge clk); resume_req = 0;
    count_busy(n);
    chk(n == 1 && vfy_cnt == 2, "R12 verify repeated", vfy_cnt, 2);
  endtask

  task automatic t_abort();
    int n;
    issue(2'd1, 3'd5, 5);
    @(negedge clk);
    abort_req = 1; susp_req = 1; @(negedge clk); abort_req = 0; susp_req = 0;
    chk(!busy && !suspended && req_ready, "R11 abort to idle", busy, 0);
    chk(invalid_bits[5] == 1 && lock_bits[5] == 1, "R11 invalid set", invalid_bits[5], 1);
    issue(2'd0, 3'd5, 1);
    count_busy(n);
    chk(invalid_bits[5] == 0 && n == PC+1, "R11 erase revives", invalid_bits[5], 0);
  endtask

  initial begin
    #(8*200000);
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_erase_loop();
    t_lock_protect();
    t_max_pulses();
    t_suspend();
    t_idle_suspend();
    t_verify_suspend();
    t_abort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule